// File: doc/BRIEF.md
# MSI Doorbell Capture Unit

This block turns message-signalled interrupts into pending flags for a host processor. A PCIe-side agent posts an inbound memory write to one programmed target address. When the address matches and capture is enabled, the low bits of the write data name a vector, and the flag for that vector is set. Software reads the pending-flag register and clears flags one bit at a time by writing ones to them. A per-vector enable register decides which pending flags drive the interrupt line.

The interrupt line to the CPU also carries the legacy (INTx-style) interrupt sources. These are modelled here as a single input. A handler that finds the pending-flag register at zero knows the request came from a legacy source.

The register port is a single-cycle write strobe with a two-bit register index. Reads are combinational from the same index. Register indices: 0 = target address low word (bit 0 is the capture enable, bits 31:1 are address bits 31:1), 1 = target address high word (address bits 63:32), 2 = pending flags (write one to clear), 3 = vector enable mask.

Top module: `msi_doorbell_unit`

## Requirements
- R1: After reset all four registers read zero, and `irq_out` follows `legacy_irq` alone.
- R2: An inbound write that hits the target with data value N (0 to 31) sets pending-flag bit N (register index 2). The flag can be read on the first clock edge after the write is presented. No other bit changes.
- R3: While bit 0 of the low target register (index 0) is zero, no inbound write sets any flag.
- R4: Address bit 0 is left out of the match. Address bits 31:1 must equal bits 31:1 of register index 0, and bits 63:32 must equal register index 1. Any write that differs in any of these bits sets no flag.
- R5: An inbound write with a data value of 32 or more sets no flag, even if it hits the target.
- R6: Writing register index 2 clears every flag whose bit in the write data is one. Bits written as zero keep their value.
- R7: When an inbound write sets bit N in the same cycle that software clears bit N, the bit ends up set.
- R8: `irq_out` is high exactly when some flag is set and its bit in the enable register (index 3) is one, or when `legacy_irq` is high.
- R9: The enable register masks only the interrupt. A flag whose enable bit is zero is still captured and still reads back as set.
- R10: While only `legacy_irq` is active, `irq_out` is high and the pending-flag register reads zero.
- R11: Registers 0, 1 and 3 read back the last value written, including the capture-enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| in_valid | input | 1 | Inbound memory write is present this cycle |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data (vector number) |
| legacy_irq | input | 1 | Combined legacy interrupt sources |
| irq_out | output | 1 | Level interrupt to the CPU |

## Verification
The assertions assume that `in_valid`, `reg_we` and their buses are stable and known at each rising edge. They also assume that a clear and a set of the same bit only meet in the single cycle in which both strobes are high. The bench keeps within this. It changes every input on the falling edge and holds each strobe for exactly one cycle. It reads results half a period later, after the edge that updates the flags. The race case drives the flag-register write and the inbound write on the same falling edge, so both land on the same rising edge.

// File: rtl/msi_dbl_pkg.sv
`timescale 1ns/1ps
package msi_dbl_pkg;
   localparam int REG_W   = 32;
   localparam int IDX_W   = 2;

   typedef enum logic [IDX_W-1:0] {
      RIDX_TGT_LO = 2'd0,
      RIDX_TGT_HI = 2'd1,
      RIDX_FLAGS  = 2'd2,
      RIDX_MASK   = 2'd3
   } reg_idx_e;
endpackage

// File: rtl/msi_cfg_regs.sv
`timescale 1ns/1ps
module msi_cfg_regs
   import msi_dbl_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int NUM_VEC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   tgt_lo,
   output logic [REG_W-1:0]   tgt_hi,
   output logic [NUM_VEC-1:0] vec_mask
);
   localparam int HI_W = ADDR_W - 32;

   logic wr_lo, wr_hi, wr_mask;
   assign wr_lo   = wr_en && (wr_idx == RIDX_TGT_LO);
   assign wr_hi   = wr_en && (wr_idx == RIDX_TGT_HI);
   assign wr_mask = wr_en && (wr_idx == RIDX_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tgt_lo <= '0;
      else if (wr_lo) tgt_lo <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vec_mask <= '0;
      else if (wr_mask) vec_mask <= wr_data[NUM_VEC-1:0];
   end

   generate
      if (HI_W > 0) begin : g_hi
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hi_q <= '0;
            else if (wr_hi) hi_q <= wr_data[HI_W-1:0];
         end
         assign tgt_hi = REG_W'(hi_q);
      end else begin : g_no_hi
         assign tgt_hi = '0;
      end
   endgenerate

   // R11: a written value is visible on the next cycle
   p_lo_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (tgt_lo == $past(wr_data)));
endmodule

// File: rtl/msi_addr_match.sv
`timescale 1ns/1ps
module msi_addr_match
   import msi_dbl_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int DATA_W  = 32,
   parameter int NUM_VEC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [ADDR_W-1:0]  in_addr,
   input  logic [DATA_W-1:0]  in_data,
   input  logic [REG_W-1:0]   tgt_lo,
   input  logic [REG_W-1:0]   tgt_hi,
   output logic [NUM_VEC-1:0] set_vec
);
   localparam int VEC_W = $clog2(NUM_VEC);
   localparam int HI_W  = ADDR_W - 32;
   localparam logic [REG_W-1:0] LO_CMP_MASK = 32'hFFFF_FFFE;

   logic cap_en, lo_hit, hi_hit, vec_ok, hit;

   assign cap_en = tgt_lo[0];
   assign lo_hit = ((in_addr[31:0] ^ tgt_lo) & LO_CMP_MASK) == '0;

   generate
      if (HI_W > 0) begin : g_hi_cmp
         assign hi_hit = (in_addr[ADDR_W-1:32] == tgt_hi[HI_W-1:0]);
      end else begin : g_lo_only
         assign hi_hit = 1'b1;
      end
   endgenerate

   assign vec_ok = (in_data < DATA_W'(NUM_VEC));
   assign hit    = in_valid && cap_en && lo_hit && hi_hit && vec_ok;

   generate
      for (genvar i = 0; i < NUM_VEC; i++) begin : g_dec
         assign set_vec[i] = hit && (in_data[VEC_W-1:0] == VEC_W'(i));
      end
   endgenerate

   // R2: one inbound write names at most one vector
   p_one_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_vec));
   // R3: capture disabled means nothing is decoded
   p_cap_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_lo[0] |-> (set_vec == '0));
   // R5: out-of-range vector numbers decode to nothing
   p_big_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data >= DATA_W'(NUM_VEC)) |-> (set_vec == '0));
   // R4: no write decoded without a valid strobe
   p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (set_vec == '0));
endmodule

// File: rtl/msi_flag_bank.sv
`timescale 1ns/1ps
module msi_flag_bank #(
   parameter int NUM_VEC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set_vec,
   input  logic               clr_we,
   input  logic [NUM_VEC-1:0] clr_data,
   input  logic [NUM_VEC-1:0] vec_mask,
   output logic [NUM_VEC-1:0] flags,
   output logic               msi_req
);
   logic [NUM_VEC-1:0] flag_q, flag_d;

   generate
      for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
         // set has priority over a simultaneous clear
         assign flag_d[i] = set_vec[i] | (flag_q[i] & ~(clr_we & clr_data[i]));

         p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]);
         p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_data[i] && !set_vec[i]) |=> !flag_q[i]);
         p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_vec[i] && !(clr_we && clr_data[i])) |=> $stable(flag_q[i]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign flags   = flag_q;
   assign msi_req = |(flag_q & vec_mask);
endmodule

// File: rtl/msi_doorbell_unit.sv
`timescale 1ns/1ps
module msi_doorbell_unit
   import msi_dbl_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int NUM_VEC = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [REG_W-1:0]  in_data,
   input  logic              legacy_irq,
   output logic              irq_out
);
   generate
      if (NUM_VEC < 2 || NUM_VEC > REG_W) begin : g_bad_vec
         $error("NUM_VEC must lie between 2 and the register width");
      end
      if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W must lie between 32 and 64");
      end
   endgenerate

   logic [REG_W-1:0]   tgt_lo, tgt_hi;
   logic [NUM_VEC-1:0] vec_mask, set_vec, flags;
   logic               msi_req, clr_we;

   msi_cfg_regs #(.ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_idx(reg_idx),
      .wr_data(reg_wdata), .tgt_lo(tgt_lo), .tgt_hi(tgt_hi),
      .vec_mask(vec_mask));

   msi_addr_match #(.ADDR_W(ADDR_W), .DATA_W(REG_W), .NUM_VEC(NUM_VEC)) u_match (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .in_data(in_data), .tgt_lo(tgt_lo), .tgt_hi(tgt_hi), .set_vec(set_vec));

   assign clr_we = reg_we && (reg_idx == RIDX_FLAGS);

   msi_flag_bank #(.NUM_VEC(NUM_VEC)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_we(clr_we),
      .clr_data(reg_wdata[NUM_VEC-1:0]), .vec_mask(vec_mask),
      .flags(flags), .msi_req(msi_req));

   always_comb begin
      unique case (reg_idx)
         RIDX_TGT_LO: reg_rdata = tgt_lo;
         RIDX_TGT_HI: reg_rdata = tgt_hi;
         RIDX_FLAGS:  reg_rdata = REG_W'(flags);
         default:     reg_rdata = REG_W'(vec_mask);
      endcase
   end

   assign irq_out = msi_req | legacy_irq;

   // R10: legacy request always reaches the CPU line
   p_legacy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_irq |-> irq_out);
   // R8: no pending flag and no legacy source keeps the line low
   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!legacy_irq && flags == '0) |-> !irq_out);
   // R9: a masked-off vector still records its flag
   p_masked_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

// File: tb/tb_msi_doorbell_unit.sv
`timescale 1ns/1ps
module tb_msi_doorbell_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_idx = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        in_valid = 1'b0;
   logic [63:0] in_addr = '0;
   logic [31:0] in_data = '0;
   logic        legacy_irq = 1'b0;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   localparam logic [63:0] TGT = 64'h0000_0000_FEE0_0000;

   always #2.5 clk = ~clk;

   msi_doorbell_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
      .in_addr(in_addr), .in_data(in_data), .legacy_irq(legacy_irq),
      .irq_out(irq_out));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] idx, input logic [31:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] idx, output logic [31:0] val);
      @(negedge clk);
      reg_idx = idx;
      #1 val = reg_rdata;
   endtask

   task automatic msi_wr(input logic [63:0] a, input logic [31:0] d);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a; in_data = d;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic flags_is(input string tag, input logic [31:0] exp);
      logic [31:0] v;
      reg_rd(2'd2, v);
      chk(tag, v, exp);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int i = 0; i < 4; i++) begin
         reg_rd(i[1:0], v);
         chk("R1 reset reg", v, 32'h0);
      end
      chk("R1 reset irq", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_readback();
      logic [31:0] v;
      reg_wr(2'd0, 32'h1234_5679);
      reg_wr(2'd1, 32'hABCD_0001);
      reg_wr(2'd3, 32'h5A5A_00FF);
      reg_rd(2'd0, v); chk("R11 lo", v, 32'h1234_5679);
      reg_rd(2'd1, v); chk("R11 hi", v, 32'hABCD_0001);
      reg_rd(2'd3, v); chk("R11 mask", v, 32'h5A5A_00FF);
      reg_wr(2'd0, TGT[31:0] | 32'h1);
      reg_wr(2'd1, 32'h0);
      reg_wr(2'd3, 32'h0);
   endtask

   task automatic t_capture();
      msi_wr(TGT, 32'd5);
      flags_is("R2 vec5", 32'h0000_0020);
      msi_wr(TGT, 32'd31);
      flags_is("R2 vec31", 32'h8000_0020);
      msi_wr(TGT, 32'd0);
      flags_is("R2 vec0", 32'h8000_0021);
      reg_wr(2'd2, 32'hFFFF_FFFF);
      flags_is("R6 clear all", 32'h0);
   endtask

   task automatic t_addr();
      msi_wr(TGT | 64'h1, 32'd3);
      flags_is("R4 bit0 ignored", 32'h0000_0008);
      msi_wr(TGT | 64'h4, 32'd4);
      flags_is("R4 low mismatch", 32'h0000_0008);
      msi_wr(TGT | 64'h1_0000_0000, 32'd6);
      flags_is("R4 high mismatch", 32'h0000_0008);
      reg_wr(2'd1, 32'h0000_0002);
      msi_wr(TGT | 64'h2_0000_0000, 32'd6);
      flags_is("R4 high match", 32'h0000_0048);
      reg_wr(2'd1, 32'h0);
      reg_wr(2'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_disable();
      reg_wr(2'd0, TGT[31:0]);
      msi_wr(TGT, 32'd9);
      flags_is("R3 capture off", 32'h0);
      reg_wr(2'd0, TGT[31:0] | 32'h1);
      msi_wr(TGT, 32'd9);
      flags_is("R3 capture on", 32'h0000_0200);
      reg_wr(2'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_range();
      msi_wr(TGT, 32'd32);
      flags_is("R5 data 32", 32'h0);
      msi_wr(TGT, 32'h0000_0101);
      flags_is("R5 data 0x101", 32'h0);
   endtask

   task automatic t_w1c();
      msi_wr(TGT, 32'd5);
      msi_wr(TGT, 32'd12);
      msi_wr(TGT, 32'd30);
      reg_wr(2'd2, 32'h0000_0020);
      flags_is("R6 one bit", 32'h4000_1000);
      reg_wr(2'd2, 32'h0);
      flags_is("R6 zeros keep", 32'h4000_1000);
      reg_wr(2'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_race();
      msi_wr(TGT, 32'd0);
      msi_wr(TGT, 32'd7);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = 2'd2; reg_wdata = 32'h0000_0081;
      in_valid = 1'b1; in_addr = TGT; in_data = 32'd7;
      @(negedge clk);
      reg_we = 1'b0; in_valid = 1'b0;
      flags_is("R7 set wins", 32'h0000_0080);
      reg_wr(2'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_mask();
      reg_wr(2'd3, 32'h0);
      msi_wr(TGT, 32'd10);
      flags_is("R9 masked still set", 32'h0000_0400);
      #1 chk("R8 masked irq low", {31'b0, irq_out}, 32'h0);
      reg_wr(2'd3, 32'h0000_0400);
      #1 chk("R8 enabled irq high", {31'b0, irq_out}, 32'h1);
      reg_wr(2'd3, 32'hFFFF_FBFF);
      #1 chk("R8 other bits irq low", {31'b0, irq_out}, 32'h0);
      reg_wr(2'd3, 32'hFFFF_FFFF);
      #1 chk("R8 all enabled", {31'b0, irq_out}, 32'h1);
      reg_wr(2'd2, 32'h0000_0400);
      #1 chk("R8 cleared irq low", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_legacy();
      @(negedge clk);
      legacy_irq = 1'b1;
      #1 chk("R10 legacy irq", {31'b0, irq_out}, 32'h1);
      flags_is("R10 flags zero", 32'h0);
      @(negedge clk);
      legacy_irq = 1'b0;
      #1 chk("R10 legacy off", {31'b0, irq_out}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_readback();
      t_capture();
      t_addr();
      t_disable();
      t_range();
      t_w1c();
      t_race();
      t_mask();
      t_legacy();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule